// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block sits between decode and the function units of an in-order pipeline. Its units have different latencies, so results may complete out of order. Each cycle it looks at the one decoded instruction waiting at issue and raises a grant only when issuing it is safe. The instruction is described by its unit class, two optional source register numbers and an optional destination register number. Issue is safe when no in-flight instruction still owes a write to a register the new one reads or writes, when the chosen unit can accept work, and when the single write-back port is free in the cycle the result will arrive.

On a grant the block does three things. It marks the destination register pending. It books the write-back port for the completion cycle in a shift-register schedule. It starts the unit's occupancy tracker if that unit cannot accept back-to-back work. Each cycle the head of the schedule is presented as the write-back of that cycle, and the pending mark of that register is released at the end of that cycle. Operands are assumed latched at unit entry, so a younger write to a register that an older instruction reads never holds issue.

Each unit class has its own occupancy tracker. It is a two-state machine: `U_FREE` (the unit can accept) and `U_BUSY` (inside the initiation interval). An accept in `U_FREE` moves it to `U_BUSY` when the interval exceeds one cycle. `U_BUSY` counts down and returns to `U_FREE` after the last blocked cycle. It stays in `U_BUSY` otherwise, and a fully pipelined class never leaves `U_FREE`.

Top module: `issue_scoreboard`

## Requirements
- R1: A read hazard holds issue. If an enabled source names a register with an outstanding write, the grant is low, including during that register's write-back cycle. The reader may be granted from the following cycle on.
- R2: A write-after-write hazard holds issue. An instruction with an enabled destination is refused while that register has an outstanding write.
- R3: A write-after-read pattern never holds issue. An instruction may write a register that an older, still-running instruction reads.
- R4: The class code sets latency and write-back timing. Code 0 is add/subtract with latency 1, code 1 is load with latency 1, code 2 is multiply with latency 3 and code 3 is divide with latency 4. An instruction granted in cycle t with a destination shows `wb_valid`=1 and `wb_reg`=its destination in cycle t+latency.
- R5: The multiply unit is partially pipelined. After a multiply is granted, another multiply is refused in the next cycle and may be granted in the cycle after.
- R6: The divider is unpipelined. After a divide is granted in cycle t, further divides are refused in cycles t+1 to t+3 and may be granted from t+4.
- R7: Add/subtract and load units are fully pipelined and accept an instruction every cycle.
- R8: One write-back per cycle. An instruction with a destination is refused if its completion cycle is already booked by an older instruction.
- R9: An instruction with no destination (`dst_en`=0) sets no pending mark, books no write-back slot and produces no write-back. It is therefore not held by write-back or write-after-write checks.
- R10: With `iss_valid` low the grant is low and no state changes.
- R11: A synchronous active-high reset clears all pending marks, all booked write-backs and all unit occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A decoded instruction is waiting at issue |
| iss_cls | input | 2 | Unit class: 0 add/sub, 1 load, 2 multiply, 3 divide |
| src_a_en | input | 1 | First source is read |
| src_a | input | 5 | First source register number |
| src_b_en | input | 1 | Second source is read |
| src_b | input | 5 | Second source register number |
| dst_en | input | 1 | Instruction writes a destination |
| dst | input | 5 | Destination register number |
| iss_grant | output | 1 | Instruction issues at the coming clock edge |
| wb_valid | output | 1 | A result is written back in this cycle |
| wb_reg | output | 5 | Register written back in this cycle |

## Verification
The grant is combinational on the present inputs and state, so it is judged in the same cycle the instruction is presented, shortly before the rising edge. Write-back outputs are registered. A grant in cycle t must show up on `wb_valid`/`wb_reg` exactly latency edges later. The stimulus table therefore pairs each cycle's instruction with the write-back expected in that same cycle, and that value comes from grants made one, three or four rows earlier. Releases of hazards are checked the cycle after the write-back. Unit-interval checks probe every blocked cycle and the first free one.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        UC_ADDSUB = 2'd0,
        UC_LOAD   = 2'd1,
        UC_MUL    = 2'd2,
        UC_DIV    = 2'd3
    } unit_cls_e;

    localparam int NUM_CLS = 4;

    typedef enum logic {
        U_FREE = 1'b0,
        U_BUSY = 1'b1
    } occ_state_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sb_pending.sv
module sb_pending #(
    parameter int NREG = 32,
    parameter int IW   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_idx,
    output logic [NREG-1:0] pend
);

    logic [NREG-1:0] pend_nx;

    always_comb begin
        pend_nx = pend;
        for (int k = 0; k < NREG; k++) begin
            if (clr_en && clr_idx == IW'(k)) pend_nx[k] = 1'b0;
            if (set_en && set_idx == IW'(k)) pend_nx[k] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_nx;
    end

    // R2: a register is only ever claimed while no write is owed to it
    a_r2_no_double_claim: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !pend[set_idx]);

    // R1: a write-back always releases a register that was marked
    a_r1_release_marked: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> pend[clr_idx]);

endmodule

// File: rtl/sb_wb_slots.sv
module sb_wb_slots #(
    parameter int DEPTH = 4,
    parameter int RW    = 5,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] q_lat,
    output logic          q_taken,
    input  logic          ins_en,
    input  logic [LW-1:0] ins_lat,
    input  logic [RW-1:0] ins_reg,
    output logic          wb_valid,
    output logic [RW-1:0] wb_reg
);

    logic [DEPTH-1:0] bk_v, bk_v_nx;
    logic [RW-1:0]    bk_r    [DEPTH];
    logic [RW-1:0]    bk_r_nx [DEPTH];

    // slot k of the state holds the write-back due k cycles from now
    always_comb begin
        q_taken = 1'b0;
        for (int k = 1; k < DEPTH; k++) begin
            if (q_lat == LW'(k)) q_taken = bk_v[k];
        end
    end

    always_comb begin
        bk_v_nx = '0;
        for (int k = 0; k < DEPTH; k++) bk_r_nx[k] = '0;
        for (int k = 0; k < DEPTH - 1; k++) begin
            bk_v_nx[k] = bk_v[k+1];
            bk_r_nx[k] = bk_r[k+1];
        end
        for (int k = 0; k < DEPTH; k++) begin
            if (ins_en && ins_lat == LW'(k + 1)) begin
                bk_v_nx[k] = 1'b1;
                bk_r_nx[k] = ins_reg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bk_v <= '0;
            for (int k = 0; k < DEPTH; k++) bk_r[k] <= '0;
        end else begin
            bk_v <= bk_v_nx;
            for (int k = 0; k < DEPTH; k++) bk_r[k] <= bk_r_nx[k];
        end
    end

    assign wb_valid = bk_v[0];
    assign wb_reg   = bk_r[0];

    // R8: a booking is never placed on a slot that is already held
    a_r8_no_overbook: assert property (@(posedge clk) disable iff (rst)
        (ins_en && ins_lat > LW'(0)) |-> !q_taken || (q_lat != ins_lat));

    // R4: a booking of latency 1 surfaces as a write-back on the next cycle
    a_r4_lat1_due: assert property (@(posedge clk) disable iff (rst)
        (ins_en && ins_lat == LW'(1)) |=> (wb_valid && wb_reg == $past(ins_reg)));

endmodule

// File: rtl/sb_unit_occ.sv
module sb_unit_occ #(
    parameter int II = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    output logic busy
);
    import sb_pkg::*;

    generate
        if (II <= 1) begin : g_full
            assign busy = 1'b0;
        end else begin : g_part
            localparam int CW = $clog2(II + 1);
            occ_state_e    st_q, st_d;
            logic [CW-1:0] cnt_q, cnt_d;

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q  <= U_FREE;
                    cnt_q <= '0;
                end else begin
                    st_q  <= st_d;
                    cnt_q <= cnt_d;
                end
            end

            always_comb begin
                st_d  = st_q;
                cnt_d = cnt_q;
                unique case (st_q)
                    U_FREE: begin
                        if (accept) begin
                            st_d  = U_BUSY;
                            cnt_d = CW'(II - 1);
                        end
                    end
                    U_BUSY: begin
                        if (cnt_q <= CW'(1)) begin
                            st_d  = U_FREE;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q - CW'(1);
                        end
                    end
                    default: begin
                        st_d  = U_FREE;
                        cnt_d = '0;
                    end
                endcase
            end

            assign busy = (st_q == U_BUSY);

            // R5 / R6: nothing is accepted inside the initiation interval
            a_r6_accept_only_free: assert property (@(posedge clk) disable iff (rst)
                accept |-> st_q == U_FREE);

            // R5: two accepts never sit on adjacent cycles
            a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
                accept |=> !accept);
        end
    endgenerate

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
    parameter int NREG    = 32,
    parameter int RIW     = 5,
    parameter int LAT_ADD = 1,
    parameter int LAT_LD  = 1,
    parameter int LAT_MUL = 3,
    parameter int LAT_DIV = 4,
    parameter int II_MUL  = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           iss_valid,
    input  logic [1:0]     iss_cls,
    input  logic           src_a_en,
    input  logic [RIW-1:0] src_a,
    input  logic           src_b_en,
    input  logic [RIW-1:0] src_b,
    input  logic           dst_en,
    input  logic [RIW-1:0] dst,
    output logic           iss_grant,
    output logic           wb_valid,
    output logic [RIW-1:0] wb_reg
);
    import sb_pkg::*;

    localparam int MAXLAT = max_of4(LAT_ADD, LAT_LD, LAT_MUL, LAT_DIV);
    localparam int LW     = $clog2(MAXLAT + 1);
    localparam int II_TAB [NUM_CLS] = '{1, 1, II_MUL, LAT_DIV};

    logic [NREG-1:0]    pend;
    logic [LW-1:0]      lat_sel;
    logic               slot_taken;
    logic [NUM_CLS-1:0] unit_busy;
    logic [NUM_CLS-1:0] unit_acc;
    logic               raw_hit, waw_hit, port_hit, unit_hit;

    always_comb begin
        unique case (unit_cls_e'(iss_cls))
            UC_ADDSUB: lat_sel = LW'(LAT_ADD);
            UC_LOAD:   lat_sel = LW'(LAT_LD);
            UC_MUL:    lat_sel = LW'(LAT_MUL);
            UC_DIV:    lat_sel = LW'(LAT_DIV);
            default:   lat_sel = LW'(LAT_ADD);
        endcase
    end

    always_comb begin
        raw_hit   = (src_a_en && pend[src_a]) || (src_b_en && pend[src_b]);
        waw_hit   = dst_en && pend[dst];
        port_hit  = dst_en && slot_taken;
        unit_hit  = unit_busy[iss_cls];
        iss_grant = iss_valid && !raw_hit && !waw_hit && !port_hit && !unit_hit;
    end

    sb_pending #(.NREG(NREG), .IW(RIW)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (iss_grant && dst_en),
        .set_idx (dst),
        .clr_en  (wb_valid),
        .clr_idx (wb_reg),
        .pend    (pend)
    );

    sb_wb_slots #(.DEPTH(MAXLAT), .RW(RIW), .LW(LW)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .q_lat    (lat_sel),
        .q_taken  (slot_taken),
        .ins_en   (iss_grant && dst_en),
        .ins_lat  (lat_sel),
        .ins_reg  (dst),
        .wb_valid (wb_valid),
        .wb_reg   (wb_reg)
    );

    for (genvar u = 0; u < NUM_CLS; u++) begin : g_unit
        assign unit_acc[u] = iss_grant && (iss_cls == 2'(u));
        sb_unit_occ #(.II(II_TAB[u])) u_occ (
            .clk    (clk),
            .rst    (rst),
            .accept (unit_acc[u]),
            .busy   (unit_busy[u])
        );
    end

    // R10: no grant without a waiting instruction
    a_r10_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> !iss_grant);

    // R11: reset leaves no write-back on the following cycle
    a_r11_reset_clears_wb: assert property (@(posedge clk)
        rst |=> !wb_valid);

    // R1: a write-back register is still marked owed during its write-back cycle
    a_r1_wb_still_marked: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> pend[wb_reg]);

    // R9: an instruction without destination never marks a register
    a_r9_no_dst_no_mark: assert property (@(posedge clk) disable iff (rst)
        (iss_grant && !dst_en && !wb_valid) |=> pend == $past(pend));

endmodule

// File: tb/sim_issue_scoreboard.sv
module sim_issue_scoreboard;

    logic       clk = 1'b0;
    logic       rst;
    logic       iss_valid;
    logic [1:0] iss_cls;
    logic       src_a_en, src_b_en, dst_en;
    logic [4:0] src_a, src_b, dst;
    logic       iss_grant, wb_valid;
    logic [4:0] wb_reg;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    issue_scoreboard u0 (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_cls(iss_cls),
        .src_a_en(src_a_en), .src_a(src_a), .src_b_en(src_b_en), .src_b(src_b),
        .dst_en(dst_en), .dst(dst), .iss_grant(iss_grant),
        .wb_valid(wb_valid), .wb_reg(wb_reg)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic       v;
        logic [1:0] c;
        logic       ae;
        logic [4:0] a;
        logic       be;
        logic [4:0] b;
        logic       de;
        logic [4:0] d;
        logic       eg;
        logic       ewv;
        logic [4:0] ewr;
    } vec_t;

    localparam int NV = 49;
    // fields: req, valid, class, a_en, a, b_en, b, d_en, d, exp_grant, exp_wb_valid, exp_wb_reg
    localparam vec_t TBL [NV] = '{
        '{4, 1,3, 1,6, 1,4, 1,6,   1, 0,0 },  // 0  R4 divide r6
        '{7, 1,1, 1,3, 0,0, 1,2,   1, 0,0 },  // 1  R7 load r2
        '{1, 1,2, 1,2, 1,4, 1,0,   0, 1,2 },  // 2  R1 mul reads r2 during its write-back
        '{1, 1,2, 1,2, 1,4, 1,0,   1, 0,0 },  // 3  R1 released
        '{1, 1,3, 1,6, 1,2, 1,8,   0, 1,6 },  // 4  R1 r6 write-back cycle
        '{4, 1,3, 1,6, 1,2, 1,8,   1, 0,0 },  // 5  R4 divide r8
        '{4, 1,0, 1,0, 1,6, 1,10,  0, 1,0 },  // 6  R4 mul result r0 due
        '{1, 1,0, 1,0, 1,6, 1,10,  1, 0,0 },  // 7  R1 sub issues
        '{4, 1,0, 1,8, 1,2, 1,6,   0, 1,10},  // 8  R4 sub result
        '{1, 1,0, 1,8, 1,2, 1,6,   0, 1,8 },  // 9  R1 r8 still owed
        '{1, 1,0, 1,8, 1,2, 1,6,   1, 0,0 },  // 10 R1 add issues
        '{2, 1,0, 1,1, 1,1, 1,6,   0, 1,6 },  // 11 R2 r6 owed
        '{2, 1,0, 1,1, 1,1, 1,6,   1, 0,0 },  // 12 R2 released
        '{10,0,0, 1,6, 0,0, 1,6,   0, 1,6 },  // 13 R10 idle
        '{8, 1,3, 1,1, 0,0, 1,20,  1, 0,0 },  // 14 R8 divide books +4
        '{8, 1,2, 1,1, 0,0, 1,21,  0, 0,0 },  // 15 R8 mul would land on same slot
        '{8, 1,2, 1,1, 0,0, 1,21,  1, 0,0 },  // 16 R8 mul next cycle ok
        '{8, 1,0, 1,1, 0,0, 1,22,  0, 0,0 },  // 17 R8 add collides with divide
        '{8, 1,0, 1,1, 0,0, 1,22,  0, 1,20},  // 18 R8 add collides with mul
        '{8, 1,0, 1,1, 0,0, 1,22,  1, 1,21},  // 19 R8 add ok
        '{4, 0,0, 0,0, 0,0, 0,0,   0, 1,22},  // 20 R4
        '{5, 1,2, 1,1, 0,0, 1,11,  1, 0,0 },  // 21 R5 mul r11
        '{5, 1,2, 1,1, 0,0, 1,12,  0, 0,0 },  // 22 R5 refused
        '{5, 1,2, 1,1, 0,0, 1,12,  1, 0,0 },  // 23 R5 accepted
        '{4, 0,0, 0,0, 0,0, 0,0,   0, 1,11},  // 24 R4
        '{4, 0,0, 0,0, 0,0, 0,0,   0, 0,0 },  // 25 R4
        '{4, 0,0, 0,0, 0,0, 0,0,   0, 1,12},  // 26 R4
        '{6, 1,3, 1,1, 0,0, 1,13,  1, 0,0 },  // 27 R6 divide r13
        '{6, 1,3, 1,1, 0,0, 1,14,  0, 0,0 },  // 28 R6 busy
        '{6, 1,3, 1,1, 0,0, 1,14,  0, 0,0 },  // 29 R6 busy
        '{6, 1,3, 1,1, 0,0, 1,14,  0, 0,0 },  // 30 R6 busy
        '{6, 1,3, 1,1, 0,0, 1,14,  1, 1,13},  // 31 R6 free
        '{6, 0,0, 0,0, 0,0, 0,0,   0, 0,0 },  // 32
        '{6, 0,0, 0,0, 0,0, 0,0,   0, 0,0 },  // 33
        '{6, 0,0, 0,0, 0,0, 0,0,   0, 0,0 },  // 34
        '{6, 0,0, 0,0, 0,0, 0,0,   0, 1,14},  // 35 R6
        '{3, 1,2, 1,16,1,17,1,15,  1, 0,0 },  // 36 R3 mul reads r16
        '{3, 1,0, 1,1, 0,0, 1,16,  1, 0,0 },  // 37 R3 younger write to r16
        '{3, 0,0, 0,0, 0,0, 0,0,   0, 1,16},  // 38 R3
        '{3, 0,0, 0,0, 0,0, 0,0,   0, 1,15},  // 39 R3
        '{7, 1,0, 1,2, 0,0, 1,1,   1, 0,0 },  // 40 R7 add
        '{7, 1,1, 1,4, 0,0, 1,3,   1, 1,1 },  // 41 R7 load
        '{7, 1,0, 1,4, 0,0, 1,5,   1, 1,3 },  // 42 R7 add
        '{7, 0,0, 0,0, 0,0, 0,0,   0, 1,5 },  // 43 R7
        '{9, 1,2, 1,1, 0,0, 1,18,  1, 0,0 },  // 44 R9 mul r18
        '{9, 0,0, 0,0, 0,0, 0,0,   0, 0,0 },  // 45
        '{9, 1,0, 1,2, 0,0, 0,18,  1, 0,0 },  // 46 R9 no-dest op ignores slot and r18
        '{9, 0,0, 0,0, 0,0, 0,0,   0, 1,18},  // 47 R9
        '{9, 0,0, 0,0, 0,0, 0,0,   0, 0,0 }   // 48 R9 no write-back from it
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] c, input logic ae, input logic [4:0] a,
                         input logic be, input logic [4:0] b, input logic de, input logic [4:0] d);
        @(negedge clk);
        iss_valid = v; iss_cls = c; src_a_en = ae; src_a = a;
        src_b_en = be; src_b = b; dst_en = de; dst = d;
        #5;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); rst = 1'b0; #5;
        chk("R11 reset wb_valid", int'(wb_valid), 0);
        chk("R10 reset idle grant", int'(iss_grant), 0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].v, TBL[i].c, TBL[i].ae, TBL[i].a, TBL[i].be, TBL[i].b, TBL[i].de, TBL[i].d);
            chk($sformatf("R%0d vec%0d grant", TBL[i].rq, i), int'(iss_grant), int'(TBL[i].eg));
            chk($sformatf("R%0d vec%0d wb_valid", TBL[i].rq, i), int'(wb_valid), int'(TBL[i].ewv));
            if (TBL[i].ewv)
                chk($sformatf("R%0d vec%0d wb_reg", TBL[i].rq, i), int'(wb_reg), int'(TBL[i].ewr));
        end

        // R11: reset in flight drops the divide and its mark
        drive(1, 2'd3, 1, 5'd1, 0, 0, 1, 5'd25);
        chk("R11 pre-reset divide grant", int'(iss_grant), 1);
        @(negedge clk); iss_valid = 1'b0; rst = 1'b1; #5;
        @(negedge clk); rst = 1'b0;
        iss_valid = 1'b1; iss_cls = 2'd3; src_a_en = 1'b1; src_a = 5'd25;
        src_b_en = 1'b0; dst_en = 1'b1; dst = 5'd26; #5;
        chk("R11 reader of cleared reg and free divider", int'(iss_grant), 1);
        chk("R11 no wb after reset", int'(wb_valid), 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R11 no wb +1", int'(wb_valid), 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R11 old divide wb dropped", int'(wb_valid), 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R11 no wb +3", int'(wb_valid), 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 post-reset divide wb_valid", int'(wb_valid), 1);
        chk("R4 post-reset divide wb_reg", int'(wb_reg), 26);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule